// File: doc/BRIEF.md
# Bus Master Latency Watchdog

This block protects a parallel-bus master from a target that never answers. While the master owns a transaction and waits for the target to become ready, a down-counter runs on the bus clock. The timeout is set from an 8-bit configuration register. Only its low nibble is stored, and that nibble becomes the upper bits of the counter. The low counter bits load as zero, so the timeout is the nibble value times 16 clocks. A nibble of zero turns the watchdog off.

Each completed data phase reloads the counter, so a slow but live target is never aborted. If the counter runs out, the block does three things. It pulses a request for the master to abort the transaction. It sets a sticky received-abort flag, which software clears by writing 1. If system-error reporting is enabled, it also pulses a system-error output. Driving the bus pins is left to the master logic around this block.

Top module: `bm_latency_wdog`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'h00 and `abort_req`, `mabort_sticky` and `serr_pulse` are all low.
- R2: A write with `cfg_we` stores `cfg_wdata[3:0]` as the limit nibble. `cfg_rdata` returns that nibble in bits [3:0], and bits [7:4] always read as 0.
- R3: While the limit nibble is 0, `abort_req` never asserts, however long `xfer_active` stays high without a data phase.
- R4: With limit nibble N != 0, the counter loads N*16 on reload. Counting starts at the edge after the reload edge. `abort_req` is high for exactly one cycle, N*16+1 clock edges after the reload edge, provided `xfer_active` stays high and no reload happens in between.
- R5: `beat_done` sampled high reloads the counter to the full limit, which restarts the timeout.
- R6: While `xfer_active` is low, the counter holds its value. When `xfer_active` returns high, counting resumes from the held value.
- R7: `mabort_sticky` is set on the same edge that raises `abort_req`. It stays set until a write with `mabort_clr_we` high and `mabort_clr` = 1. A write with `mabort_clr` = 0 has no effect. An expiry on the same edge as a clear leaves the flag set.
- R8: `serr_pulse` is high for one cycle, together with `abort_req`, only if `serr_en` was high at the expiry edge. Otherwise it stays low.
- R9: A write with `cfg_we` also reloads the counter, using the newly written nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_wdata | input | 8 | Limit register write data |
| cfg_rdata | output | 8 | Limit register read value |
| mabort_clr_we | input | 1 | Status write strobe |
| mabort_clr | input | 1 | Status write data; 1 clears the sticky flag |
| xfer_active | input | 1 | Master owns a transaction and waits on the target |
| beat_done | input | 1 | A data phase completed this cycle |
| serr_en | input | 1 | System-error reporting enable |
| abort_req | output | 1 | One-cycle master-abort request |
| mabort_sticky | output | 1 | Sticky received-abort flag |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
All three outputs are registered, so an abort is visible in the cycle after the expiry edge. If a reload is sampled at edge k+1, the abort appears N*16+2 cycles after the bench drove the reload at cycle k. After an idle gap, a resumed count with R cycles left expires R+1 cycles after `xfer_active` is raised again. The driver computes each expected abort cycle from these rules and queues it with the expected system-error level. A monitor samples on the falling edge, pops the queue on every abort and compares the cycle number. Any abort or error pulse that was not queued counts as a mismatch. Register reads and the sticky flag are sampled one full cycle after the write that changes them.

// File: rtl/bm_latency_wdog.sv
module bm_latency_wdog #(
  parameter int REG_W = 8,
  parameter int NIB_W = 4,
  parameter int LOW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             mabort_clr_we,
  input  logic             mabort_clr,
  input  logic             xfer_active,
  input  logic             beat_done,
  input  logic             serr_en,
  output logic             abort_req,
  output logic             mabort_sticky,
  output logic             serr_pulse
);

  localparam int CNT_W = NIB_W + LOW_W;
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'((1 << NIB_W) - 1);

  logic [REG_W-1:0] lim_reg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             abort_q, sticky_q, serr_q;

  wire [NIB_W-1:0] lim_nib  = lim_reg_q[NIB_W-1:0];
  wire             armed    = |lim_nib;
  wire [CNT_W-1:0] full_val = {lim_nib, {LOW_W{1'b0}}};
  wire [CNT_W-1:0] new_val  = {cfg_wdata[NIB_W-1:0], {LOW_W{1'b0}}};
  wire             running  = armed && xfer_active && !beat_done && !cfg_we;
  wire             expire   = running && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) lim_reg_q <= '0;
    else if (cfg_we) lim_reg_q <= cfg_wdata & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (cfg_we)              cnt_q <= new_val;
    else if (beat_done || expire) cnt_q <= full_val;
    else if (running)             cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_q  <= 1'b0;
      serr_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      abort_q <= expire;
      serr_q  <= expire && serr_en;
      if (expire)                           sticky_q <= 1'b1;
      else if (mabort_clr_we && mabort_clr) sticky_q <= 1'b0;
    end
  end

  assign cfg_rdata     = lim_reg_q;
  assign abort_req     = abort_q;
  assign mabort_sticky = sticky_q;
  assign serr_pulse    = serr_q;

  p_zero_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata == '0 && !cfg_we) |=> !abort_req);

  p_single_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && !cfg_we && !beat_done) |=> $stable(cnt_q));

  p_abort_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> mabort_sticky);

  p_sticky_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mabort_sticky && !(mabort_clr_we && mabort_clr)) |=> mabort_sticky);

  p_serr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> (abort_req && $past(serr_en)));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata[REG_W-1:NIB_W] == '0));

endmodule

// File: tb/bm_latency_wdog_tb_top.sv
module bm_latency_wdog_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       mabort_clr_we = 1'b0;
  logic       mabort_clr = 1'b0;
  logic       xfer_active = 1'b0;
  logic       beat_done = 1'b0;
  logic       serr_en = 1'b0;
  logic       abort_req, mabort_sticky, serr_pulse;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int exp_cyc[$];
  bit exp_serr[$];

  bm_latency_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mabort_clr_we(mabort_clr_we), .mabort_clr(mabort_clr),
    .xfer_active(xfer_active), .beat_done(beat_done), .serr_en(serr_en),
    .abort_req(abort_req), .mabort_sticky(mabort_sticky), .serr_pulse(serr_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) step();
  endtask

  task automatic push_exp(int c, bit s);
    exp_cyc.push_back(c);
    exp_serr.push_back(s);
  endtask

  task automatic write_cfg(logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic clear_sticky(bit d);
    mabort_clr_we = 1'b1; mabort_clr = d;
    step();
    mabort_clr_we = 1'b0; mabort_clr = 1'b0;
  endtask

  // Monitor: compares each abort against the scoreboard queue (R4, R5, R6, R8, R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (abort_req) begin
        if (exp_cyc.size() == 0) begin
          check(1'b0, "R3", "unexpected abort at cycle", cyc, -1);
        end else begin
          int ec; bit es;
          ec = exp_cyc.pop_front();
          es = exp_serr.pop_front();
          check(cyc == ec, "R4", "abort cycle", cyc, ec);
          check(serr_pulse == es, "R8", "serr with abort", int'(serr_pulse), int'(es));
        end
      end else if (serr_pulse) begin
        check(1'b0, "R8", "serr without abort", 1, 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check(cfg_rdata == 8'h00, "R1", "cfg_rdata", cfg_rdata, 0);
    check(!abort_req && !serr_pulse, "R1", "pulses", int'(abort_req | serr_pulse), 0);
    check(!mabort_sticky, "R1", "sticky", int'(mabort_sticky), 0);

    // R3 disabled watchdog: long wait with no data phase
    serr_en = 1'b1;
    xfer_active = 1'b1;
    repeat (300) step();
    xfer_active = 1'b0;
    step();
    check(!mabort_sticky, "R3", "sticky after idle limit", int'(mabort_sticky), 0);

    // R2 reserved bits read as 0
    write_cfg(8'hF2);
    check(cfg_rdata == 8'h02, "R2", "cfg_rdata", cfg_rdata, 2);

    // R4 timeout with N=2 and serr enabled
    k = cyc;
    xfer_active = 1'b1; beat_done = 1'b1;
    push_exp(k + 32 + 2, 1'b1);
    step();
    beat_done = 1'b0;
    wait_until(k + 34);
    step();
    xfer_active = 1'b0;
    check(mabort_sticky, "R7", "sticky set by abort", int'(mabort_sticky), 1);

    // R7 write of 0 has no effect, write of 1 clears
    clear_sticky(1'b0);
    check(mabort_sticky, "R7", "sticky after write 0", int'(mabort_sticky), 1);
    clear_sticky(1'b1);
    check(!mabort_sticky, "R7", "sticky after write 1", int'(mabort_sticky), 0);

    // R5 beat reloads, N=3, serr disabled (R8)
    write_cfg(8'h03);
    check(cfg_rdata == 8'h03, "R2", "cfg_rdata", cfg_rdata, 3);
    serr_en = 1'b0;
    k = cyc;
    xfer_active = 1'b1; beat_done = 1'b1;
    step();
    beat_done = 1'b0;
    wait_until(k + 30);
    k = cyc;
    beat_done = 1'b1;
    push_exp(k + 48 + 2, 1'b0);
    step();
    beat_done = 1'b0;
    wait_until(k + 50);
    step();
    xfer_active = 1'b0;
    check(exp_cyc.size() == 0, "R5", "pending aborts", exp_cyc.size(), 0);

    // R6 idle hold: N=1, four decrements then idle, 12 remain
    serr_en = 1'b1;
    write_cfg(8'h01);
    k = cyc;
    xfer_active = 1'b1; beat_done = 1'b1;
    step();
    beat_done = 1'b0;
    wait_until(k + 5);
    xfer_active = 1'b0;
    repeat (50) step();
    check(!abort_req, "R6", "abort while idle", int'(abort_req), 0);
    k = cyc;
    xfer_active = 1'b1;
    push_exp(k + 12 + 1, 1'b1);
    wait_until(k + 13);
    step();
    xfer_active = 1'b0;
    check(exp_cyc.size() == 0, "R6", "pending aborts", exp_cyc.size(), 0);
    clear_sticky(1'b1);
    check(!mabort_sticky, "R7", "sticky cleared", int'(mabort_sticky), 0);

    // R9 config write reloads with new nibble; R7 set wins over clear
    write_cfg(8'h02);
    k = cyc;
    xfer_active = 1'b1; beat_done = 1'b1;
    step();
    beat_done = 1'b0;
    wait_until(k + 20);
    k = cyc;
    cfg_we = 1'b1; cfg_wdata = 8'h01;
    push_exp(k + 16 + 2, 1'b1);
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
    wait_until(k + 17);
    mabort_clr_we = 1'b1; mabort_clr = 1'b1;
    step();
    mabort_clr_we = 1'b0; mabort_clr = 1'b0;
    xfer_active = 1'b0;
    step();
    check(mabort_sticky, "R7", "set wins over clear", int'(mabort_sticky), 1);
    check(cfg_rdata == 8'h01, "R9", "cfg_rdata", cfg_rdata, 1);

    repeat (5) step();
    check(exp_cyc.size() == 0, "R9", "pending aborts", exp_cyc.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule